// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block tells a flash controller when a program or erase operation running inside a parallel NOR flash has ended, and whether it ended badly. The command sequencer starts it with a 32-bit iteration budget once the operation's command words have gone out. Typical budgets are 0x1400 for a word or buffer program, 0xA00000 for a block erase and 0x30000000 for a whole-chip erase.

The poller works in two phases. First it watches the device's ready/busy line. It waits while the line is high, then waits while the line is low, and each of those two waits is capped at the budget. It then runs the status phase. In each iteration it takes two back-to-back reads of the status word at the device base address and compares the toggle bit of the two words. If the toggle bit has stopped moving, the operation is over. If it is still moving, the poller takes a second pair of reads. A stopped toggle bit in that pair also means success. Otherwise the failure-flag bit of the first word in that pair decides whether the run ends with an error or goes on to the next iteration.

The bus reads go through a request/grant port that the poller shares with the command sequencer. The outcome is reported as a one-cycle done pulse together with a two-bit result code.

Top module: `toggle_poller`

## Requirements
- R1: After reset, busy_o, done_o and rd_req_o are low and result_o is 0.
- R2: A start pulse in the idle state latches timeout_i as the budget T. The poller then spends up to T cycles waiting while the synchronised ready/busy level is 1, reloads T, and spends up to T cycles waiting while that level is 0. With no ready/busy movement and a grant in every cycle, a run whose first status pair already matches raises done_o exactly T+5 clock edges after the start edge.
- R3: Every status read requests the address BASE_ADDR on rd_addr_o.
- R4: In each status iteration the poller takes two consecutive granted reads. If bit 6 of the two words is equal, the run ends with result 0 (success) after exactly 2 reads in that iteration.
- R5: If bit 6 differs, a second pair of reads follows. If bit 6 of that pair is equal, the result is 0. If it differs and bit 5 of the first word of the pair is 1, the result is 1 (error). If it differs and bit 5 is 0, a new iteration starts.
- R6: The status phase runs at most T iterations. When the budget is used up, the result is 2 (timeout). With T = 0 no status read is made and done_o rises 3 edges after the start edge.
- R7: done_o is high for exactly one cycle per run, result_o is valid in that cycle, and busy_o is high from the cycle after the start edge until done_o.
- R8: A start pulse that arrives while busy_o is high is ignored. The running operation's result and read count do not change.
- R9: rb_i passes through a two-flop synchroniser. A level that first appears in the cycle of the start pulse is not seen by the first wait phase.
- R10: rd_req_o is only high during the status phase and stays high until rd_gnt_i is high. rd_data_i is taken in the cycle of the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| timeout_i | input | 32 | Iteration budget, latched on an accepted start |
| rb_i | input | 1 | Asynchronous ready/busy level from the device |
| rd_req_o | output | 1 | Read request to the shared flash bus |
| rd_addr_o | output | AW | Read address, always BASE_ADDR |
| rd_gnt_i | input | 1 | Grant. The read completes in this cycle |
| rd_data_i | input | DW | Status word, valid with the grant |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 0 success, 1 error, 2 timeout |

## Verification
The result is decided at the clock edge that grants the deciding read, or at the edge where the budget is found empty. done_o is registered, so it shows up one edge later. In the directed cases every read is granted at once, which gives a completion latency of T+5 edges for a first-pair success, 3 edges for a zero budget, and 5 edges when ready/busy rises only together with the start pulse. The bench counts clock edges from the start edge and samples done_o on the falling edge after each rising edge. In the random cases the grants stall, so latency is not predicted there. Those runs check only the result code and the number of granted reads, both computed by a bench model.

// File: rtl/tgp_pkg.sv
package tgp_pkg;

  typedef enum logic [1:0] {
    RES_OK  = 2'd0,
    RES_ERR = 2'd1,
    RES_TMO = 2'd2
  } tgp_res_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT_HI,
    S_WAIT_LO,
    S_ITER,
    S_RD_A,
    S_RD_B,
    S_RD_C,
    S_RD_D
  } tgp_state_t;

  // Toggle bit has stopped when it matches between two consecutive reads.
  function automatic logic tog_settled(input logic [63:0] w0, input logic [63:0] w1,
                                       input int tog_bit);
    return w0[tog_bit] == w1[tog_bit];
  endfunction

  function automatic logic fail_seen(input logic [63:0] w, input int err_bit);
    return w[err_bit];
  endfunction

endpackage

// File: rtl/tgp_sync.sv
module tgp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/tgp_count.sv
module tgp_count #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          dec_i,
  input  logic [CW-1:0] val_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cnt_q <= '0;
    else if (load_i)  cnt_q <= val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  // R6: the budget never wraps below zero
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/toggle_poller.sv
module toggle_poller
  import tgp_pkg::*;
#(
  parameter int          DW        = 16,
  parameter int          AW        = 24,
  parameter int          CW        = 32,
  parameter int          SYNC_FF   = 2,
  parameter int          TOG_BIT   = 6,
  parameter int          ERR_BIT   = 5,
  parameter logic [AW-1:0] BASE_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] timeout_i,
  input  logic          rb_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_gnt_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    result_o
);
  localparam int WPAD = 64 - DW;

  tgp_state_t    st_q, st_nx;
  logic [CW-1:0] tmo_q;
  logic [DW-1:0] hold_q;
  logic          done_q;
  tgp_res_t      res_q;

  logic          rb_s;
  logic          cnt_load, cnt_dec, cnt_zero;
  logic [CW-1:0] cnt_val, cnt_cur;
  logic          grab, fin;
  tgp_res_t      fin_res;

  // Named events for the checks
  logic          rd_fire, pair_eval, pair_same, pair_fail;

  tgp_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rb_i), .q_o(rb_s)
  );

  tgp_count #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(cnt_load), .dec_i(cnt_dec),
    .val_i(cnt_val), .cnt_o(cnt_cur), .zero_o(cnt_zero)
  );

  assign rd_req_o  = (st_q == S_RD_A) || (st_q == S_RD_B) ||
                     (st_q == S_RD_C) || (st_q == S_RD_D);
  assign rd_addr_o = BASE_ADDR;
  assign rd_fire   = rd_req_o && rd_gnt_i;
  assign pair_eval = rd_fire && ((st_q == S_RD_B) || (st_q == S_RD_D));
  assign pair_same = tog_settled({{WPAD{1'b0}}, hold_q}, {{WPAD{1'b0}}, rd_data_i}, TOG_BIT);
  assign pair_fail = fail_seen({{WPAD{1'b0}}, hold_q}, ERR_BIT);
  assign cnt_val   = (st_q == S_IDLE) ? timeout_i : tmo_q;

  always_comb begin
    st_nx    = st_q;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    grab     = 1'b0;
    fin      = 1'b0;
    fin_res  = RES_OK;
    unique case (st_q)
      S_IDLE: if (start_i) begin
        cnt_load = 1'b1;
        st_nx    = S_WAIT_HI;
      end
      S_WAIT_HI: if (rb_s && !cnt_zero) cnt_dec = 1'b1;
                 else begin cnt_load = 1'b1; st_nx = S_WAIT_LO; end
      S_WAIT_LO: if (!rb_s && !cnt_zero) cnt_dec = 1'b1;
                 else begin cnt_load = 1'b1; st_nx = S_ITER; end
      S_ITER: if (cnt_zero) begin fin = 1'b1; fin_res = RES_TMO; end
              else begin cnt_dec = 1'b1; st_nx = S_RD_A; end
      S_RD_A: if (rd_gnt_i) begin grab = 1'b1; st_nx = S_RD_B; end
      S_RD_B: if (rd_gnt_i) begin
        if (pair_same) fin = 1'b1;
        else           st_nx = S_RD_C;
      end
      S_RD_C: if (rd_gnt_i) begin grab = 1'b1; st_nx = S_RD_D; end
      S_RD_D: if (rd_gnt_i) begin
        if (pair_same)      fin = 1'b1;
        else if (pair_fail) begin fin = 1'b1; fin_res = RES_ERR; end
        else                st_nx = S_ITER;
      end
      default: st_nx = S_IDLE;
    endcase
    if (fin) st_nx = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q   <= S_IDLE;
      tmo_q  <= '0;
      hold_q <= '0;
      done_q <= 1'b0;
      res_q  <= RES_OK;
    end else begin
      st_q   <= st_nx;
      done_q <= fin;
      if (fin) res_q <= fin_res;
      if (grab) hold_q <= rd_data_i;
      if (st_q == S_IDLE && start_i) tmo_q <= timeout_i;
    end

  assign busy_o   = (st_q != S_IDLE);
  assign done_o   = done_q;
  assign result_o = res_q;

  // R7: completion pulse lasts one cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R7: only defined codes are reported
  a_r7_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (result_o != 2'd3));
  // R10: a pending request is not withdrawn before its grant
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_gnt_i) |=> rd_req_o);
  // R8: the latched budget is untouched by a start while busy
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(tmo_q));
  // R4 / R5: a matched pair ends the run as success
  a_r4_settled_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_eval && pair_same) |=> (done_o && result_o == RES_OK));
  // R6: an empty budget at an iteration start ends in timeout
  a_r6_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_ITER && cnt_zero) |=> (done_o && result_o == RES_TMO && !busy_o));
endmodule

// File: tb/toggle_poller_bench.sv
module toggle_poller_bench;
  localparam logic [23:0] BASE = 24'h000000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] tmo = '0;
  logic        rb = 1'b0;
  logic        rd_req, rd_gnt, busy, done;
  logic [23:0] rd_addr;
  logic [15:0] rd_data;
  logic [1:0]  result;
  logic        gnt_en = 1'b1;
  logic        rand_gnt = 1'b0;
  logic        clr = 1'b0;
  int          rd_idx = 0;
  logic [15:0] w [64];
  int          n_tests = 0, n_fail = 0;
  logic        addr_bad = 1'b0, req_idle_bad = 1'b0;
  logic        finished = 1'b0;

  always #2 clk = ~clk;

  assign rd_gnt  = rd_req & gnt_en;
  assign rd_data = w[rd_idx[5:0]];

  toggle_poller #(.AW(24), .BASE_ADDR(BASE)) u_toggle_poller (
    .clk(clk), .rst_n(rst_n), .start_i(start), .timeout_i(tmo), .rb_i(rb),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_gnt_i(rd_gnt), .rd_data_i(rd_data),
    .busy_o(busy), .done_o(done), .result_o(result)
  );

  always @(posedge clk)
    if (clr) rd_idx <= 0;
    else if (rd_req && rd_gnt) begin
      rd_idx <= rd_idx + 1;
      if (rd_addr != BASE) addr_bad <= 1'b1;
    end

  always @(negedge clk) begin
    gnt_en <= rand_gnt ? 1'($urandom % 2) : 1'b1;
    if (rst_n && !busy && rd_req) req_idle_bad <= 1'b1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bench model of the status phase: result code and number of reads.
  function automatic int model(input int t, output int nreads);
    int i = 0;
    logic [15:0] a, b;
    for (int k = 0; k < t; k++) begin
      a = w[i]; b = w[i+1]; i += 2;
      if (a[6] == b[6]) begin nreads = i; return 0; end
      a = w[i]; b = w[i+1]; i += 2;
      if (a[6] == b[6]) begin nreads = i; return 0; end
      if (a[5]) begin nreads = i; return 1; end
    end
    nreads = i;
    return 2;
  endfunction

  task automatic run(input int t, input logic rb_lvl, input bit rb_late,
                     input bit inject, input int exp_lat, input string req);
    int n, er, en, lat;
    bit seen;
    er = model(t, en);
    @(negedge clk); clr = 1'b1; rb = rb_late ? 1'b0 : rb_lvl;
    @(negedge clk); clr = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; tmo = t; if (rb_late) rb = rb_lvl;
    @(negedge clk); start = 1'b0;
    n = 0; seen = 0; lat = -1;
    while (!seen && n < 4000) begin
      @(posedge clk); n++;
      @(negedge clk);
      start = (inject && (n == 2 || n == 3)) ? 1'b1 : 1'b0;
      if (inject) tmo = 0;
      if (done) begin seen = 1; lat = n; end
    end
    start = 1'b0;
    check(seen && result == er[1:0], {req, " result"}, result, er);
    check(rd_idx == en, {req, " reads"}, rd_idx, en);
    if (exp_lat >= 0) check(lat == exp_lat, {req, " latency"}, lat, exp_lat);
    @(negedge clk);
    check(!done && !busy, "R7 single pulse", done, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    end
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < 64; i++) w[i] = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !rd_req && result == 2'd0, "R1 reset", {busy, done, rd_req}, 0);
    rst_n = 1'b1;
    // R2 R4: first pair settled, ready/busy low or high
    run(4, 1'b0, 0, 0, 9, "R2 R4 rb low");
    run(4, 1'b1, 0, 0, 9, "R2 rb high");
    // R9: level rising with start is not yet visible
    run(6, 1'b1, 1, 0, 5, "R9 sync");
    // R6: zero budget
    run(0, 1'b0, 0, 0, 3, "R6 zero budget");
    // R5: second pair differs with fail flag -> error
    w[0] = 16'h0040; w[1] = 16'h0000; w[2] = 16'h0060; w[3] = 16'h0020;
    run(3, 1'b0, 0, 0, -1, "R5 error");
    // R5: second pair settles -> success
    w[2] = 16'h0040; w[3] = 16'h0040;
    run(3, 1'b0, 0, 0, -1, "R5 second pair ok");
    // R6: toggling forever without the fail flag
    for (int i = 0; i < 64; i++) w[i] = (i % 2) ? 16'h0000 : 16'h0040;
    run(3, 1'b0, 0, 0, -1, "R6 exhaust");
    // R8: start while busy is ignored
    run(2, 1'b0, 0, 1, -1, "R8 start ignored");
    // Random runs with stalled grants (R10)
    rand_gnt = 1'b1;
    for (int r = 0; r < 40; r++) begin
      for (int i = 0; i < 64; i++) begin
        w[i] = 16'($urandom);
        if ($urandom % 3 != 0) w[i][6] = i[0];
      end
      run(int'($urandom % 6), 1'($urandom % 2), 0, 0, -1, "R10 R5 random");
    end
    rand_gnt = 1'b0;
    check(!addr_bad, "R3 address", addr_bad, 0);
    check(!req_idle_bad, "R10 no idle request", req_idle_bad, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    end
    $finish;
  end
endmodule